// File: doc/BRIEF.md
# Sticky Error Code Aggregator with Test Injection

This block gathers single-cycle error pulses from up to sixteen FIFOs, up to six state machines and one hardened-counter comparator into a 32-bit read-only error code. Each source owns a fixed bit. A FIFO error also records what kind of fault it was in three shared type bits: a write into a full FIFO, a read from an empty FIFO, or a FIFO that reports full and empty at the same time. Every bit that is captured stays set until reset. A state-machine or counter error raises a fatal-alert request. Any captured error sets an interrupt state bit, which is gated by an enable.

Software reaches the block through a small write port with four addresses. A test write names an error bit number, and the block injects one pulse on that bit through the same capture, type and interrupt path that real errors use. A lock bit closes the test register once software clears it.

The interface carries only control and status. Every pin is a plain level or pulse and there is no valid/ready handshake. A write is taken in any cycle where `wr_en_i` is high, and the block never applies back-pressure.

Top module: `err_code_agg`

## Requirements
- R1: A one-cycle pulse on `fifo_err_i[i]` sets `err_code_o[i]` at the next rising clock edge.
- R2: When FIFO i errors, its 3-bit kind field `fifo_kind_i[3*i +: 3]` is taken in the same cycle. Kind bit 0 (write while full) sets `err_code_o[28]`, kind bit 1 (read while empty) sets bit 29, and kind bit 2 (full and empty at once) sets bit 30. The kind bits of FIFOs that are not erroring have no effect.
- R3: `sm_err_i[k]` sets `err_code_o[20+k]`, and `cnt_err_i` sets `err_code_o[26]`, each at the next edge.
- R4: Every set bit of `err_code_o` stays set until reset. No write to any address clears it.
- R5: `fatal_alert_o` is high exactly while any of bits 20 to 26 is set. FIFO and type bits alone leave it low.
- R6: Any newly captured error, including an injected one, sets `intr_state_o` at the next edge. Writing address 3 with data bit 0 = 1 clears it, and a capture in the same cycle wins over the clear. Writing address 2 loads data bit 0 into `intr_en_o`. `intr_o` is high when both the state bit and the enable are set.
- R7: While `lock_o` is 1, a write to address 1 with data bits 4:0 = n forces one pulse on error bit n. The bit is then set at the next edge.
- R8: An injection on a FIFO bit n also sets type bits from `fifo_kind_i` of FIFO n, sampled in the write cycle.
- R9: `lock_o` resets to 1. A write to address 0 with data bit 0 = 0 clears it, and nothing sets it again before reset. While it is 0, writes to address 1 inject nothing.
- R10: Bits 16 to 19, 27 and 31 always read 0. An injection aimed at them changes neither `err_code_o` nor `intr_state_o`.
- R11: After reset, `err_code_o`, `intr_state_o`, `intr_en_o`, `intr_o` and `fatal_alert_o` are 0 and `lock_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_err_i | input | NFifo | Per-FIFO error pulses |
| fifo_kind_i | input | 3*NFifo | Per-FIFO error kind: bit 0 write-full, bit 1 read-empty, bit 2 full-and-empty |
| sm_err_i | input | NSm | Illegal-state pulses from state machines |
| cnt_err_i | input | 1 | Hardened-counter mismatch pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 lock, 1 test injection, 2 interrupt enable, 3 interrupt clear |
| wr_data_i | input | 32 | Write data |
| err_code_o | output | 32 | Sticky error code |
| fatal_alert_o | output | 1 | Fatal-alert request |
| intr_state_o | output | 1 | Sticky interrupt state |
| intr_en_o | output | 1 | Interrupt enable |
| intr_o | output | 1 | Interrupt request |
| lock_o | output | 1 | Test-register write enable |

## Verification
The bench builds the block with its default values, sixteen FIFOs and six state machines. These fill every assigned bit position, so each reserved hole between fields (16 to 19, 27, 31) sits next to a live field. Injection to those holes and to the edge positions 15, 26 and 30 can therefore be checked against neighbours that really capture. The full width of the kind bus is also driven, so a kind bit on an idle FIFO can be shown to be ignored.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;
  localparam int unsigned CodeW    = 32;
  localparam int unsigned FifoLsb  = 0;
  localparam int unsigned SmLsb    = 20;
  localparam int unsigned CntBit   = 26;
  localparam int unsigned TypeLsb  = 28;
  localparam int unsigned NumKinds = 3;
  localparam int unsigned SelW     = $clog2(CodeW);

  typedef enum logic [1:0] {
    AddrLock    = 2'd0,
    AddrTest    = 2'd1,
    AddrIntrEn  = 2'd2,
    AddrIntrClr = 2'd3
  } reg_addr_e;

  function automatic logic [CodeW-1:0] valid_mask(int unsigned nfifo, int unsigned nsm);
    logic [CodeW-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nfifo; i++) m[FifoLsb+i] = 1'b1;
    for (int unsigned i = 0; i < nsm; i++)   m[SmLsb+i]   = 1'b1;
    m[CntBit] = 1'b1;
    for (int unsigned i = 0; i < NumKinds; i++) m[TypeLsb+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/err_fifo_class.sv
module err_fifo_class
  import err_agg_pkg::*;
#(
  parameter int unsigned NFifo = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NFifo-1:0]          hit_i,
  input  logic [NFifo*NumKinds-1:0] kind_i,
  output logic [NumKinds-1:0]       type_o
);
  for (genvar k = 0; k < NumKinds; k++) begin : g_kind
    logic [NFifo-1:0] sel;
    for (genvar f = 0; f < NFifo; f++) begin : g_fifo
      assign sel[f] = hit_i[f] & kind_i[f*NumKinds+k];
    end
    assign type_o[k] = |sel;
  end

  // R2: a type can only be reported when some FIFO is erroring
  p_type_needs_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_o != '0) |-> (hit_i != '0));
endmodule

// File: rtl/err_sticky_reg.sv
module err_sticky_reg #(
  parameter int unsigned     W    = 32,
  parameter logic [W-1:0]    Mask = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= q | (set_i & Mask);
  end
  assign q_o = q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    // R4: a captured bit never falls without reset
    p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q[b] |=> q[b]);
    if (!Mask[b]) begin : g_res
      // R10: reserved positions never rise
      p_reserved_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !q[b]);
    end
  end
endmodule

// File: rtl/err_test_ctrl.sv
module err_test_ctrl
  import err_agg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CodeW-1:0] wr_data_i,
  input  logic             ev_any_i,
  output logic [CodeW-1:0] inj_o,
  output logic             lock_o,
  output logic             intr_state_o,
  output logic             intr_en_o
);
  logic lock_q, state_q, en_q;
  logic wr_lock, wr_test, wr_en_reg, wr_clr;

  assign wr_lock   = wr_en_i && (wr_addr_i == AddrLock);
  assign wr_test   = wr_en_i && (wr_addr_i == AddrTest) && lock_q;
  assign wr_en_reg = wr_en_i && (wr_addr_i == AddrIntrEn);
  assign wr_clr    = wr_en_i && (wr_addr_i == AddrIntrClr) && wr_data_i[0];

  always_comb begin
    inj_o = '0;
    if (wr_test) inj_o[wr_data_i[SelW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b1;
      state_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (wr_lock && !wr_data_i[0]) lock_q <= 1'b0;
      if (wr_en_reg) en_q <= wr_data_i[0];
      if (ev_any_i)    state_q <= 1'b1;
      else if (wr_clr) state_q <= 1'b0;
    end
  end

  assign lock_o       = lock_q;
  assign intr_state_o = state_q;
  assign intr_en_o    = en_q;

  // R9: once cleared, the lock stays cleared
  p_lock_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |=> !lock_q);
  // R9: no injection while locked
  p_inj_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |-> (inj_o == '0));
  // R7: an injection targets at most one bit
  p_inj_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inj_o));
  // R6: a capture always leaves the interrupt state set
  p_intr_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_any_i |=> state_q);
endmodule

// File: rtl/err_code_agg.sv
module err_code_agg
  import err_agg_pkg::*;
#(
  parameter int unsigned NFifo = 16,
  parameter int unsigned NSm   = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NFifo-1:0]          fifo_err_i,
  input  logic [NFifo*NumKinds-1:0] fifo_kind_i,
  input  logic [NSm-1:0]            sm_err_i,
  input  logic                      cnt_err_i,
  input  logic                      wr_en_i,
  input  logic [1:0]                wr_addr_i,
  input  logic [CodeW-1:0]          wr_data_i,
  output logic [CodeW-1:0]          err_code_o,
  output logic                      fatal_alert_o,
  output logic                      intr_state_o,
  output logic                      intr_en_o,
  output logic                      intr_o,
  output logic                      lock_o
);
  localparam logic [CodeW-1:0] ValidMask = valid_mask(NFifo, NSm);

  logic [CodeW-1:0]    inj_vec, set_vec, code_q;
  logic [NFifo-1:0]    fifo_hit;
  logic [NumKinds-1:0] type_hit;
  logic                ev_any;

  assign fifo_hit = fifo_err_i | inj_vec[FifoLsb +: NFifo];

  err_fifo_class #(.NFifo(NFifo)) u_class (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (fifo_hit),
    .kind_i (fifo_kind_i),
    .type_o (type_hit)
  );

  always_comb begin
    set_vec = inj_vec;
    set_vec[FifoLsb +: NFifo]   = fifo_hit;
    set_vec[SmLsb +: NSm]       = inj_vec[SmLsb +: NSm] | sm_err_i;
    set_vec[CntBit]             = inj_vec[CntBit] | cnt_err_i;
    set_vec[TypeLsb +: NumKinds] = inj_vec[TypeLsb +: NumKinds] | type_hit;
  end

  assign ev_any = |(set_vec & ValidMask);

  err_sticky_reg #(.W(CodeW), .Mask(ValidMask)) u_code (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .q_o    (code_q)
  );

  err_test_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .ev_any_i     (ev_any),
    .inj_o        (inj_vec),
    .lock_o       (lock_o),
    .intr_state_o (intr_state_o),
    .intr_en_o    (intr_en_o)
  );

  assign err_code_o    = code_q;
  assign fatal_alert_o = (|code_q[SmLsb +: NSm]) | code_q[CntBit];
  assign intr_o        = intr_state_o & intr_en_o;

  // R1: FIFO pulse captured at the next edge
  p_fifo_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_err_i[0] |=> err_code_o[FifoLsb]);
  // R3 / R5: counter mismatch leads to fatal alert
  p_cnt_alert_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_err_i |=> (err_code_o[CntBit] && fatal_alert_o));
  // R5: state machine error leads to fatal alert
  p_sm_alert_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sm_err_i[0] |=> fatal_alert_o);
  // R6: a request needs an enable
  p_intr_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> (intr_en_o && intr_state_o));
endmodule

// File: tb/tb_err_code_agg.sv
`timescale 1ns/1ps
module tb_err_code_agg;
  localparam int NFifo = 16;
  localparam int NSm   = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NFifo-1:0]  fifo_err = '0;
  logic [NFifo*3-1:0] fifo_kind = '0;
  logic [NSm-1:0]    sm_err = '0;
  logic              cnt_err = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [31:0]       err_code;
  logic              fatal, istate, ien, intr, lock;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  err_code_agg #(.NFifo(NFifo), .NSm(NSm)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_err_i(fifo_err), .fifo_kind_i(fifo_kind),
    .sm_err_i(sm_err), .cnt_err_i(cnt_err), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .err_code_o(err_code), .fatal_alert_o(fatal),
    .intr_state_o(istate), .intr_en_o(ien), .intr_o(intr), .lock_o(lock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fifo_err = '0; fifo_kind = '0; sm_err = '0; cnt_err = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 code", err_code, 32'h0);
    chk("R11 lock", {31'b0, lock}, 32'h1);
    chk("R11 alert", {31'b0, fatal}, 32'h0);
    chk("R11 intr", {29'b0, istate, ien, intr}, 32'h0);
  endtask

  task automatic t_fifo();
    do_reset();
    fifo_err[3] = 1'b1; fifo_kind[9 +: 3] = 3'b001;
    fifo_kind[12 +: 3] = 3'b110;  // idle FIFO 4, must be ignored (R2)
    @(negedge clk);
    fifo_err = '0; fifo_kind = '0;
    chk("R1 R2 fifo3 wr-full", err_code, 32'h1000_0008);
    chk("R5 fifo no alert", {31'b0, fatal}, 32'h0);
    fifo_err[15] = 1'b1; fifo_kind[45 +: 3] = 3'b010;
    @(negedge clk);
    fifo_err = '0; fifo_kind = '0;
    chk("R1 R2 fifo15 rd-empty", err_code, 32'h3000_8008);
    do_reset();
    fifo_err[0] = 1'b1; fifo_err[7] = 1'b1; fifo_kind[0 +: 3] = 3'b100;
    @(negedge clk);
    fifo_err = '0; fifo_kind = '0;
    chk("R1 R2 fifo0+7 both", err_code, 32'h4000_0081);
  endtask

  task automatic t_sm_cnt();
    do_reset();
    sm_err[2] = 1'b1;
    @(negedge clk);
    sm_err = '0;
    chk("R3 sm2", err_code, 32'h0040_0000);
    chk("R5 sm alert", {31'b0, fatal}, 32'h1);
    do_reset();
    sm_err[5] = 1'b1;
    @(negedge clk);
    sm_err = '0;
    chk("R3 sm5", err_code, 32'h0200_0000);
    do_reset();
    cnt_err = 1'b1;
    @(negedge clk);
    cnt_err = 1'b0;
    chk("R3 cnt", err_code, 32'h0400_0000);
    chk("R5 cnt alert", {31'b0, fatal}, 32'h1);
  endtask

  task automatic t_sticky();
    do_reset();
    fifo_err[5] = 1'b1;
    @(negedge clk);
    fifo_err = '0;
    wr(2'd3, 32'hffff_ffff);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'hffff_ffff);
    repeat (10) @(negedge clk);
    chk("R4 sticky", err_code, 32'h0000_0020);
  endtask

  task automatic t_intr();
    do_reset();
    fifo_err[1] = 1'b1;
    @(negedge clk);
    fifo_err = '0;
    chk("R6 state set, disabled", {30'b0, istate, intr}, 32'h2);
    wr(2'd2, 32'h1);
    chk("R6 enabled", {29'b0, istate, ien, intr}, 32'h7);
    wr(2'd3, 32'h1);
    chk("R6 w1c", {29'b0, istate, ien, intr}, 32'h2);
    fifo_err[2] = 1'b1;
    wr(2'd3, 32'h1);
    fifo_err = '0;
    chk("R6 set wins", {31'b0, istate}, 32'h1);
    wr(2'd3, 32'h0);
    chk("R6 w0 no clear", {31'b0, istate}, 32'h1);
  endtask

  task automatic t_inject();
    do_reset();
    fifo_kind[27 +: 3] = 3'b010;
    wr(2'd1, 32'd9);
    fifo_kind = '0;
    chk("R7 R8 inject fifo9", err_code, 32'h2000_0200);
    chk("R6 inject intr", {31'b0, istate}, 32'h1);
    wr(2'd1, 32'd24);
    chk("R7 inject sm4", err_code, 32'h2100_0200);
    chk("R5 inject alert", {31'b0, fatal}, 32'h1);
    do_reset();
    wr(2'd1, 32'd30);
    chk("R7 inject type bit", err_code, 32'h4000_0000);
    do_reset();
    wr(2'd1, 32'd15);
    chk("R8 inject no kind", err_code, 32'h0000_8000);
  endtask

  task automatic t_reserved();
    do_reset();
    wr(2'd1, 32'd16);
    wr(2'd1, 32'd19);
    wr(2'd1, 32'd27);
    wr(2'd1, 32'd31);
    chk("R10 reserved code", err_code, 32'h0);
    chk("R10 reserved intr", {31'b0, istate}, 32'h0);
  endtask

  task automatic t_lock();
    do_reset();
    wr(2'd0, 32'h1);
    chk("R9 write one keeps", {31'b0, lock}, 32'h1);
    wr(2'd0, 32'h0);
    chk("R9 cleared", {31'b0, lock}, 32'h0);
    wr(2'd1, 32'd4);
    chk("R9 inject blocked", err_code, 32'h0);
    wr(2'd0, 32'h1);
    chk("R9 stays cleared", {31'b0, lock}, 32'h0);
    fifo_err[4] = 1'b1;
    @(negedge clk);
    fifo_err = '0;
    chk("R9 R1 capture after lock", err_code, 32'h0000_0010);
  endtask

  initial begin
    t_reset();
    t_fifo();
    t_sm_cnt();
    t_sticky();
    t_intr();
    t_inject();
    t_reserved();
    t_lock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule